// File: doc/BRIEF.md
# I2C Passive Bus Monitor

This block watches the two wires of an I2C bus and never drives them. It runs on a system clock much faster than the bus and oversamples both lines. Each line passes through a short synchronizer chain. The synchronized values are then compared with the samples taken one clock earlier, which finds the clock rising edges and the start and stop conditions.

A three-state controller (`MON_WAIT_START`, `MON_ADDR`, `MON_DATA`) turns these line events into typed records. Each record is held for one clock and carries:
- an event code,
- the decoded byte,
- the raw nine-bit frame,
- the acknowledge flag.

A START moves the controller from `MON_WAIT_START`, or from `MON_DATA`, into `MON_ADDR`. The ninth captured bit of an address frame moves it from `MON_ADDR` to `MON_DATA`. It stays in `MON_DATA` for any number of data frames. A STOP seen in `MON_DATA` returns it to `MON_WAIT_START`. The direction taken from the last address frame labels every data frame that follows it as a write or a read.

Top module: `i2c_bus_monitor`

## Requirements
- R1: A falling SDA while SCL is high, seen in `MON_WAIT_START`, emits event code 0 (START) and moves the controller into `MON_ADDR`.
- R2: A START seen in `MON_DATA`, with no STOP since the previous START, emits event code 1 (repeated START) and moves the controller to `MON_ADDR`.
- R3: A rising SDA while SCL is high, seen in `MON_DATA`, emits event code 6 (STOP) and returns the controller to `MON_WAIT_START`. The next START is then reported as code 0 again.
- R4: In `MON_ADDR` and `MON_DATA`, each SCL rising edge captures SDA, and nine captures complete one frame. `evt_raw` holds the frame with the first captured bit in bit 8 and the acknowledge bit in bit 0. `evt_nack` equals bit 0, where 1 means NACK.
- R5: The frame that completes in `MON_ADDR` emits code 2 (address write) when `evt_raw` bit 1 is 0, and code 3 (address read) when it is 1. For this frame `evt_byte` is `evt_raw[8:2]` with a zero in bit 7.
- R6: A frame that completes in `MON_DATA` emits code 4 (data write) or code 5 (data read), as set by the direction bit of the last address frame. For these frames `evt_byte` is `evt_raw[8:1]`. Any number of data frames may follow one address frame.
- R7: In `MON_WAIT_START`, SCL pulses and STOP patterns emit no event.
- R8: In `MON_ADDR`, START and STOP patterns on the lines are ignored, and only SCL rising edges are acted on.
- R9: An accepted START clears any partly collected frame, so the next frame is built from the nine captures that follow that START.
- R10: `evt_valid` is low during reset and on the first clock after reset. Each record lasts exactly one clock. START, repeated START and STOP records carry zero in `evt_byte`, `evt_raw` and `evt_nack`.
- R11: A line change first sampled on one clock edge produces its record on the `SYNC_STAGES`-th rising edge after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line, observed only |
| sda_in | input | 1 | Bus data line, observed only |
| evt_valid | output | 1 | One-clock strobe for an event record |
| evt_code | output | 3 | 0 START, 1 repeated START, 2 addr write, 3 addr read, 4 data write, 5 data read, 6 STOP |
| evt_byte | output | 8 | Slave address or data byte |
| evt_raw | output | 9 | Raw frame, first bit in bit 8, acknowledge bit in bit 0 |
| evt_nack | output | 1 | 1 when the acknowledge bit was high |

## Verification
The bench builds the block with the default `SYNC_STAGES` of 2. Its reference model delays the lines by that same parameter, so the record latency is checked on every clock and not only at event boundaries. Each bus bit is held for six system clocks. This brings several line patterns within reach:
- STOP patterns while idle;
- START and STOP patterns inside an address frame;
- a repeated START that cuts off a partial data frame;
- a NACK on the final byte.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;

    localparam int FRAME_BITS   = 9;
    localparam int PAYLOAD_BITS = FRAME_BITS - 1;
    localparam int CNT_W        = $clog2(FRAME_BITS);

    typedef enum logic [2:0] {
        EVT_START   = 3'd0,
        EVT_RSTART  = 3'd1,
        EVT_ADDR_WR = 3'd2,
        EVT_ADDR_RD = 3'd3,
        EVT_DATA_WR = 3'd4,
        EVT_DATA_RD = 3'd5,
        EVT_STOP    = 3'd6
    } evt_code_e;

    typedef enum logic [1:0] {
        MON_WAIT_START = 2'd0,
        MON_ADDR       = 2'd1,
        MON_DATA       = 2'd2
    } mon_state_e;

endpackage

// File: rtl/i2cmon_sync.sv
// Multi-stage synchronizer for a group of asynchronous lines.
module i2cmon_sync #(
    parameter int              WIDTH   = 2,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] IDLE_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                chain_q[i] <= IDLE_VAL;
            end
        end else begin
            chain_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/i2cmon_cond.sv
// Line condition detector: compares each synchronized sample with the one before.
module i2cmon_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic start_seen,
    output logic stop_seen,
    output logic primed
);

    logic scl_prev_q;
    logic sda_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
            primed     <= 1'b0;
        end else begin
            scl_prev_q <= scl_s;
            sda_prev_q <= sda_s;
            primed     <= 1'b1;
        end
    end

    // No condition is reported until one sample has been stored.
    assign scl_rise   = primed && !scl_prev_q && scl_s;
    assign start_seen = primed && sda_prev_q && !sda_s && scl_s;
    assign stop_seen  = primed && !sda_prev_q && sda_s && scl_s;

endmodule

// File: rtl/i2cmon_frame.sv
// Frame collector: shifts in payload bits, counts captures.
module i2cmon_frame
    import i2cmon_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  shift_en,
    input  logic                  bit_in,
    output logic [CNT_W-1:0]      count,
    output logic                  at_last,
    output logic [FRAME_BITS-1:0] word_next
);

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BITS - 1);

    logic [PAYLOAD_BITS-1:0] shift_q;

    assign at_last   = (count == LAST_IDX);
    assign word_next = {shift_q, bit_in};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
            count   <= '0;
        end else if (clear || (shift_en && at_last)) begin
            shift_q <= '0;
            count   <= '0;
        end else if (shift_en) begin
            shift_q <= {shift_q[PAYLOAD_BITS-2:0], bit_in};
            count   <= count + 1'b1;
        end
    end

endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
    import i2cmon_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       evt_valid,
    output logic [2:0] evt_code,
    output logic [7:0] evt_byte,
    output logic [8:0] evt_raw,
    output logic       evt_nack
);

    logic [1:0] lines_s;
    logic       scl_rise, start_seen, stop_seen, primed;
    logic       frame_clear, frame_shift, frame_last;
    logic [CNT_W-1:0]      frame_cnt;
    logic [FRAME_BITS-1:0] frame_word;

    mon_state_e state_q, state_d;
    logic       rep_q, rep_d;
    logic       dir_q, dir_d;

    logic                    nx_valid;
    evt_code_e               nx_code;
    logic [PAYLOAD_BITS-1:0] nx_byte;
    logic [FRAME_BITS-1:0]   nx_raw;
    logic                    nx_nack;

    i2cmon_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .IDLE_VAL(2'b11)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_in, sda_in}),
        .q     (lines_s)
    );

    i2cmon_cond u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_s      (lines_s[1]),
        .sda_s      (lines_s[0]),
        .scl_rise   (scl_rise),
        .start_seen (start_seen),
        .stop_seen  (stop_seen),
        .primed     (primed)
    );

    i2cmon_frame u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (frame_clear),
        .shift_en  (frame_shift),
        .bit_in    (lines_s[0]),
        .count     (frame_cnt),
        .at_last   (frame_last),
        .word_next (frame_word)
    );

    // Next-state and next-record logic.
    always_comb begin
        state_d     = state_q;
        rep_d       = rep_q;
        dir_d       = dir_q;
        frame_clear = 1'b0;
        frame_shift = 1'b0;
        nx_valid    = 1'b0;
        nx_code     = EVT_START;
        nx_byte     = '0;
        nx_raw      = '0;
        nx_nack     = 1'b0;

        unique case (state_q)
            MON_WAIT_START: begin
                if (start_seen) begin
                    nx_valid    = 1'b1;
                    nx_code     = rep_q ? EVT_RSTART : EVT_START;
                    rep_d       = 1'b1;
                    dir_d       = 1'b0;
                    frame_clear = 1'b1;
                    state_d     = MON_ADDR;
                end
            end
            MON_ADDR: begin
                if (scl_rise) begin
                    frame_shift = 1'b1;
                    if (frame_last) begin
                        nx_valid = 1'b1;
                        nx_raw   = frame_word;
                        nx_nack  = frame_word[0];
                        nx_byte  = {1'b0, frame_word[FRAME_BITS-1:2]};
                        nx_code  = frame_word[1] ? EVT_ADDR_RD : EVT_ADDR_WR;
                        dir_d    = frame_word[1];
                        state_d  = MON_DATA;
                    end
                end
            end
            MON_DATA: begin
                if (scl_rise) begin
                    frame_shift = 1'b1;
                    if (frame_last) begin
                        nx_valid = 1'b1;
                        nx_raw   = frame_word;
                        nx_nack  = frame_word[0];
                        nx_byte  = frame_word[FRAME_BITS-1:1];
                        nx_code  = dir_q ? EVT_DATA_RD : EVT_DATA_WR;
                    end
                end else if (start_seen) begin
                    nx_valid    = 1'b1;
                    nx_code     = rep_q ? EVT_RSTART : EVT_START;
                    rep_d       = 1'b1;
                    dir_d       = 1'b0;
                    frame_clear = 1'b1;
                    state_d     = MON_ADDR;
                end else if (stop_seen) begin
                    nx_valid = 1'b1;
                    nx_code  = EVT_STOP;
                    rep_d    = 1'b0;
                    dir_d    = 1'b0;
                    state_d  = MON_WAIT_START;
                end
            end
            default: begin
                state_d = MON_WAIT_START;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MON_WAIT_START;
            rep_q   <= 1'b0;
            dir_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            rep_q   <= rep_d;
            dir_q   <= dir_d;
        end
    end

    // Output record register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_valid <= 1'b0;
            evt_code  <= '0;
            evt_byte  <= '0;
            evt_raw   <= '0;
            evt_nack  <= 1'b0;
        end else begin
            evt_valid <= nx_valid;
            evt_code  <= nx_valid ? nx_code : '0;
            evt_byte  <= nx_byte;
            evt_raw   <= nx_raw;
            evt_nack  <= nx_nack;
        end
    end

endmodule

// File: rtl/i2cmon_checker.sv
module i2cmon_checker
    import i2cmon_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             evt_valid,
    input logic [2:0]       evt_code,
    input mon_state_e       state_q,
    input logic [CNT_W-1:0] bit_cnt,
    input logic             primed
);

    AST_START_ENTERS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && (evt_code == EVT_START || evt_code == EVT_RSTART)) |-> (state_q == MON_ADDR)); // R1
    AST_RSTART_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_code == EVT_RSTART) |-> ($past(state_q) == MON_DATA)); // R2
    AST_STOP_TO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_code == EVT_STOP) |-> (state_q == MON_WAIT_START)); // R3
    AST_FRAME_NINTH_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_code >= EVT_ADDR_WR && evt_code <= EVT_DATA_RD) |-> ($past(bit_cnt) == CNT_W'(FRAME_BITS - 1))); // R4
    AST_ADDR_FROM_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && (evt_code == EVT_ADDR_WR || evt_code == EVT_ADDR_RD)) |-> ($past(state_q) == MON_ADDR)); // R5
    AST_DATA_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && (evt_code == EVT_DATA_WR || evt_code == EVT_DATA_RD)) |-> ($past(state_q) == MON_DATA)); // R6
    AST_WAIT_ONLY_START: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && $past(state_q) == MON_WAIT_START) |-> (evt_code == EVT_START || evt_code == EVT_RSTART)); // R7
    AST_UNPRIMED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !primed |=> !evt_valid); // R10

endmodule

bind i2c_bus_monitor i2cmon_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_valid (evt_valid),
    .evt_code  (evt_code),
    .state_q   (state_q),
    .bit_cnt   (frame_cnt),
    .primed    (primed)
);

// File: tb/tb_i2c_bus_monitor.sv
module tb_i2c_bus_monitor;

    localparam int CLK_PERIOD = 10;
    localparam int SYNC       = 2;
    localparam int HOLD       = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda = 1'b1;
    logic       evt_valid;
    logic [2:0] evt_code;
    logic [7:0] evt_byte;
    logic [8:0] evt_raw;
    logic       evt_nack;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    i2c_bus_monitor #(.SYNC_STAGES(SYNC)) dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda),
        .evt_valid(evt_valid), .evt_code(evt_code), .evt_byte(evt_byte),
        .evt_raw(evt_raw), .evt_nack(evt_nack)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- behavioural reference model ----------------
    bit m_scl_h[$];
    bit m_sda_h[$];
    int m_state, m_cnt, m_shift, m_rep, m_dir, m_edges;
    int x_v, x_code, x_byte, x_raw, x_nack;

    task automatic model_reset();
        m_scl_h = {};
        m_sda_h = {};
        for (int i = 0; i <= SYNC; i++) begin
            m_scl_h.push_back(1'b1);
            m_sda_h.push_back(1'b1);
        end
        m_state = 0; m_cnt = 0; m_shift = 0; m_rep = 0; m_dir = 0; m_edges = 0;
        x_v = 0; x_code = 0; x_byte = 0; x_raw = 0; x_nack = 0;
    endtask

    task automatic m_emit_start();
        x_v = 1; x_code = m_rep ? 1 : 0;
        m_rep = 1; m_dir = 0; m_cnt = 0; m_shift = 0; m_state = 1;
    endtask

    task automatic m_capture(input int b);
        m_shift = ((m_shift << 1) | b) & 'h1FF;
        m_cnt++;
        if (m_cnt == 9) begin
            x_v = 1; x_raw = m_shift; x_nack = m_shift & 1;
            if (m_state == 1) begin
                m_dir = (m_shift >> 1) & 1;
                x_code = 2 + m_dir;
                x_byte = m_shift >> 2;
                m_state = 2;
            end else begin
                x_code = 4 + m_dir;
                x_byte = (m_shift >> 1) & 'hFF;
            end
            m_cnt = 0; m_shift = 0;
        end
    endtask

    task automatic model_step();
        int cs, cp, ds, dp;
        bit rise, st, sp;
        cs = m_scl_h[SYNC-1]; cp = m_scl_h[SYNC];
        ds = m_sda_h[SYNC-1]; dp = m_sda_h[SYNC];
        rise = (m_edges >= 1) && cp == 0 && cs == 1;
        st   = (m_edges >= 1) && dp == 1 && ds == 0 && cs == 1;
        sp   = (m_edges >= 1) && dp == 0 && ds == 1 && cs == 1;
        x_v = 0; x_code = 0; x_byte = 0; x_raw = 0; x_nack = 0;
        case (m_state)
            0: if (st) m_emit_start();
            1: if (rise) m_capture(ds);
            default: begin
                if (rise) m_capture(ds);
                else if (st) m_emit_start();
                else if (sp) begin
                    x_v = 1; x_code = 6; m_rep = 0; m_dir = 0; m_state = 0;
                end
            end
        endcase
        m_scl_h.push_front(scl); void'(m_scl_h.pop_back());
        m_sda_h.push_front(sda); void'(m_sda_h.pop_back());
        m_edges++;
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else model_step();
    end

    function automatic string tag_for(input int v, input int code);
        if (!v) return "R7";
        case (code)
            0: return "R1";
            1: return "R2";
            2, 3: return "R5";
            4, 5: return "R6";
            default: return "R3";
        endcase
    endfunction

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (int'(evt_valid) != x_v || int'(evt_code) != x_code || int'(evt_byte) != x_byte ||
                int'(evt_raw) != x_raw || int'(evt_nack) != x_nack) begin
                errors++;
                $display("FAIL %s/R11 cycle compare: got v=%0d c=%0d b=%h r=%h n=%0d exp v=%0d c=%0d b=%h r=%h n=%0d",
                         tag_for(x_v, x_code), evt_valid, evt_code, evt_byte, evt_raw, evt_nack,
                         x_v, x_code, x_byte, x_raw, x_nack);
            end
        end
    end

    // event log
    int lg_code[$];
    int lg_byte[$];
    int lg_raw[$];
    int lg_nack[$];
    always @(negedge clk) begin
        if (rst_n && evt_valid) begin
            lg_code.push_back(evt_code); lg_byte.push_back(evt_byte);
            lg_raw.push_back(evt_raw);   lg_nack.push_back(evt_nack);
        end
    end

    task automatic check(input string tag, input int got, input int exp, input string what);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    // ---------------- bus stimulus ----------------
    task automatic hold();
        repeat (HOLD) @(negedge clk);
    endtask

    task automatic send_bit(input bit b);
        sda = b; hold(); scl = 1'b1; hold(); scl = 1'b0; hold();
    endtask

    task automatic send_byte(input logic [7:0] b, input bit ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        send_bit(ack);
    endtask

    task automatic do_start();
        sda = 1'b1; hold(); scl = 1'b1; hold(); sda = 1'b0; hold(); scl = 1'b0; hold();
    endtask

    task automatic do_stop();
        sda = 1'b0; hold(); scl = 1'b1; hold(); sda = 1'b1; hold();
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    int exp_code[15] = '{0, 2, 4, 4, 6, 0, 3, 5, 1, 2, 4, 6, 0, 3, 6};
    int exp_byte[15] = '{0, 'h50, 'h3C, 'hFF, 0, 0, 'h2B, 'h81, 0, 'h11, 'h5A, 0, 0, 'h30, 0};
    int exp_raw[15]  = '{0, 'h140, 'h078, 'h1FF, 0, 0, 'h0AE, 'h102, 0, 'h044, 'h0B5, 0, 0, 'h0C2, 0};
    int exp_nack[15] = '{0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0};
    string exp_tag[15] = '{"R1", "R5", "R6", "R4", "R3", "R3", "R5", "R6", "R2", "R9", "R6", "R3", "R1", "R8", "R3"};

    initial begin : main
        int lat;
        repeat (3) @(negedge clk);
        check("R10", evt_valid, 0, "valid in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", evt_valid, 0, "valid on first clock after reset");
        repeat (10) @(negedge clk);

        // R7: idle noise, SCL pulses and a STOP pattern
        scl = 1'b0; hold(); sda = 1'b0; hold(); scl = 1'b1; hold();
        sda = 1'b1; hold(); scl = 1'b0; hold(); scl = 1'b1; hold();
        check("R7", lg_code.size(), 0, "events while waiting");

        // write transfer, with R11 latency measurement on the START
        lat = 0;
        sda = 1'b0;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            if (evt_valid && lat == 0) lat = k;
        end
        check("R11", lat, SYNC + 1, "START latency in negedges");
        hold(); scl = 1'b0; hold();
        send_byte(8'hA0, 1'b0);
        send_byte(8'h3C, 1'b0);
        send_byte(8'hFF, 1'b1);
        do_stop();

        // read transfer, partial frame cut by a repeated START
        do_start();
        send_byte(8'h57, 1'b0);
        send_byte(8'h81, 1'b0);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        do_start();
        send_byte(8'h22, 1'b0);
        send_byte(8'h5A, 1'b1);
        do_stop();

        // R8: START/STOP patterns inside the address frame
        do_start();
        sda = 1'b0; hold(); scl = 1'b1; hold();
        sda = 1'b1; hold(); sda = 1'b0; hold(); scl = 1'b0; hold();
        send_bit(1); send_bit(1); send_bit(0); send_bit(0);
        send_bit(0); send_bit(0); send_bit(1);
        send_bit(0);
        do_stop();
        repeat (10) @(negedge clk);

        check("R10", lg_code.size(), 15, "event count");
        for (int i = 0; i < 15 && i < lg_code.size(); i++) begin
            check(exp_tag[i], lg_code[i], exp_code[i], $sformatf("event %0d code", i));
            check(exp_tag[i], lg_byte[i], exp_byte[i], $sformatf("event %0d byte", i));
            check(exp_tag[i], lg_raw[i],  exp_raw[i],  $sformatf("event %0d raw", i));
            check(exp_tag[i], lg_nack[i], exp_nack[i], $sformatf("event %0d nack", i));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule